// File: doc/BRIEF.md
# MDIO Management Master

This block is the bus master for the two-wire station management link between a MAC-side controller and Ethernet PHYs. It drives a divided management clock (`mdc`) and a tri-state data line, given here as `mdio_o` with enable `mdio_oe`, returning through `mdio_i`. Each request carries a direction, a 5-bit PHY port, a 21-bit register address, an extended-addressing flag and 16 bits of write data. Both frame styles share the same wires.

A short-address request serialises one 64-bit frame. An extended request serialises two frames: an address frame carrying the 16-bit register offset, then one idle MDC period with the line released, then the read or write frame carrying the device identifier. Every frame starts with 32 one bits. Fields go out most significant bit first. The master changes the data line just after MDC falls and samples just before MDC rises. On completion the block pulses `done` and, for reads, updates `rdata`. If the PHY fails to pull the second turnaround bit low, `err` pulses with `done` and `rdata` becomes all ones.

The sequencer has four states. ST_IDLE moves to ST_ADDR on an extended request and to ST_DATA on a short one. ST_ADDR moves to ST_GAP when the address frame ends. ST_GAP moves to ST_DATA on the next MDC falling point. ST_DATA returns to ST_IDLE when its frame ends, which raises `done`.

Top module: `mdio_master`

## Requirements
- R1: After reset and whenever no request is in progress, `busy`, `mdc` and `mdio_oe` are all low.
- R2: While busy, `mdc` is high for exactly CLK_DIV system clocks and low for CLK_DIV system clocks, so one bit period is 2*CLK_DIV clocks.
- R3: Every frame opens with 32 bit periods in which `mdio_oe` is high and `mdio_o` is 1.
- R4: A short-address frame (`req_ext`=0) sends start bits 0,1, then opcode 1,0 for read or 0,1 for write, then `req_phy` and `req_addr[4:0]`, each most significant bit first.
- R5: An extended request first sends an address frame: start 0,0, opcode 0,0, `req_phy`, device identifier `req_addr[20:16]`, turnaround 1,0 driven, then `req_addr[15:0]`, most significant bit first.
- R6: After the address frame, `mdio_oe` stays low for one full MDC period (one rising edge). Then a second frame follows with start 0,0, opcode 1,1 for read or 0,1 for write, `req_phy` and `req_addr[20:16]`.
- R7: In a write frame, the turnaround bits 1,0 are driven, followed by `req_wdata` most significant bit first.
- R8: In a read frame, `mdio_oe` is low from the first turnaround bit to the frame's end. The 16 bits sampled from `mdio_i` at MDC rising edges after the second turnaround bit appear on `rdata`, first sampled bit as bit 15.
- R9: If the second turnaround bit of a read is sampled as 1, `err` is high in the `done` cycle and `rdata` becomes 16'hFFFF. A correct turnaround gives `err` low.
- R10: `done` is a single-cycle pulse in the first cycle after the final frame's last bit period, with `busy` already low in that cycle.
- R11: A request presented while `busy` is high is ignored: no extra frame is sent and the running result is unchanged. A request presented in the `done` cycle is accepted.
- R12: `mdio_o` changes only right after an MDC falling point, so it is stable when MDC rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_read | input | 1 | 1 = read, 0 = write |
| req_ext | input | 1 | 1 = extended addressing (two frames) |
| req_phy | input | 5 | PHY port address |
| req_addr | input | 21 | Register address; [20:16] device id, [15:0] offset in extended mode; [4:0] register in short mode |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Request in progress |
| done | output | 1 | Completion pulse |
| err | output | 1 | Read turnaround fault, valid with done |
| rdata | output | 16 | Read data |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line drive enable |
| mdio_i | input | 1 | Data line input |

## Verification
The two functions that can fall in the same cycle are the completion of one request (`done` rising as `busy` drops) and the acceptance of the next. The bench presents a new request on the exact cycle where `done` is seen. It then checks that the first result is intact and that the second request's frames match bit for bit, with MDC timing unbroken. A related collision, a request arriving in mid-frame, is also provoked. It is judged by the recorded number of MDC rising edges and by the unchanged result of the running request.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    typedef enum logic [2:0] {
        K_SHORT_RD,
        K_SHORT_WR,
        K_EXT_ADR,
        K_EXT_RD,
        K_EXT_WR
    } frame_kind_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_GAP,
        ST_DATA
    } seq_state_t;

    // start code (2 bits) followed by opcode (2 bits)
    function automatic logic [3:0] frame_code(frame_kind_t k);
        logic [3:0] c;
        unique case (k)
            K_SHORT_RD: c = 4'b0110;
            K_SHORT_WR: c = 4'b0101;
            K_EXT_ADR:  c = 4'b0000;
            K_EXT_RD:   c = 4'b0011;
            K_EXT_WR:   c = 4'b0001;
            default:    c = 4'b0000;
        endcase
        return c;
    endfunction

    function automatic logic kind_is_read(frame_kind_t k);
        return (k == K_SHORT_RD) || (k == K_EXT_RD);
    endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int CLK_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CW = $clog2(CLK_DIV + 1);

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap      = (cnt == CW'(CLK_DIV - 1));
    assign rise_tick = en && wrap && !mdc;
    assign fall_tick = en && wrap && mdc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (!en) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // checker: length of each high phase of mdc
    logic        mdc_q;
    logic [15:0] run_len;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mdc_q   <= 1'b0;
            run_len <= '0;
        end else begin
            mdc_q   <= mdc;
            run_len <= (mdc != mdc_q || !en) ? 16'd1 : run_len + 16'd1;
        end
    end

    assert_mdc_half_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mdc_q && !mdc) |-> (run_len == 16'(CLK_DIV)));

    assert_mdc_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !$past(en)) |-> !mdc);

endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
    import mdio_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  frame_kind_t kind,
    input  logic [4:0]  phy,
    input  logic [4:0]  field5,
    input  logic [15:0] payload,
    input  logic        fall_tick,
    input  logic        rise_tick,
    input  logic        mdio_i,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic        active,
    output logic        last,
    output logic [15:0] rdata,
    output logic        ta_err
);
    localparam int FB      = PRE_LEN + 32;
    localparam int IW      = $clog2(FB);
    localparam int REL_IDX = PRE_LEN + 14;
    localparam int TA2_IDX = PRE_LEN + 15;
    localparam int DAT_IDX = PRE_LEN + 16;

    logic [FB-1:0] sreg;
    logic [IW-1:0] idx;
    logic          rd_q;

    assign mdio_o = sreg[FB-1];
    assign last   = active && fall_tick && (idx == IW'(FB - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg    <= '0;
            idx     <= '0;
            active  <= 1'b0;
            mdio_oe <= 1'b0;
            rd_q    <= 1'b0;
        end else if (start) begin
            sreg    <= {{PRE_LEN{1'b1}}, frame_code(kind), phy, field5,
                        kind_is_read(kind) ? 18'h0 : {2'b10, payload}};
            idx     <= '0;
            active  <= 1'b1;
            mdio_oe <= 1'b1;
            rd_q    <= kind_is_read(kind);
        end else if (active && fall_tick) begin
            if (idx == IW'(FB - 1)) begin
                active  <= 1'b0;
                mdio_oe <= 1'b0;
            end else begin
                idx  <= idx + 1'b1;
                sreg <= {sreg[FB-2:0], 1'b0};
                if (rd_q && idx == IW'(REL_IDX - 1))
                    mdio_oe <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata  <= '0;
            ta_err <= 1'b0;
        end else if (start) begin
            ta_err <= 1'b0;
        end else if (active && rise_tick && rd_q) begin
            if (idx == IW'(TA2_IDX))
                ta_err <= mdio_i;
            if (idx >= IW'(DAT_IDX))
                rdata <= {rdata[14:0], mdio_i};
        end
    end

    assert_preamble_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (active && idx < IW'(PRE_LEN)) |-> (mdio_oe && mdio_o));

    assert_read_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && rd_q && idx >= IW'(REL_IDX)) |-> !mdio_oe);

    assert_change_on_fall_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_oe && $past(mdio_oe) && mdio_o != $past(mdio_o)) |-> $past(fall_tick));

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int CLK_DIV = 2,
    parameter int PRE_LEN = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_read,
    input  logic        req_ext,
    input  logic [4:0]  req_phy,
    input  logic [20:0] req_addr,
    input  logic [15:0] req_wdata,
    output logic        busy,
    output logic        done,
    output logic        err,
    output logic [15:0] rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    seq_state_t  state, state_n;
    logic        rd_q;
    logic [4:0]  phy_q;
    logic [4:0]  dev_q;
    logic [15:0] wd_q;

    logic        rise_tick, fall_tick;
    logic        fr_start, fr_active, fr_last, fr_ta_err;
    frame_kind_t fr_kind;
    logic [4:0]  fr_phy, fr_f5;
    logic [15:0] fr_payload, fr_rdata;

    assign busy = (state != ST_IDLE);

    mdio_clkgen #(.CLK_DIV(CLK_DIV)) u_clkgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (busy),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    // frame launch selection
    always_comb begin
        fr_start   = 1'b0;
        fr_kind    = K_SHORT_WR;
        fr_phy     = phy_q;
        fr_f5      = dev_q;
        fr_payload = wd_q;
        unique case (state)
            ST_IDLE: begin
                fr_start = req_valid;
                fr_phy   = req_phy;
                if (req_ext) begin
                    fr_kind    = K_EXT_ADR;
                    fr_f5      = req_addr[20:16];
                    fr_payload = req_addr[15:0];
                end else begin
                    fr_kind    = req_read ? K_SHORT_RD : K_SHORT_WR;
                    fr_f5      = req_addr[4:0];
                    fr_payload = req_wdata;
                end
            end
            ST_GAP: begin
                fr_start = fall_tick;
                fr_kind  = rd_q ? K_EXT_RD : K_EXT_WR;
            end
            default: ;
        endcase
    end

    mdio_frame #(.PRE_LEN(PRE_LEN)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (fr_start),
        .kind      (fr_kind),
        .phy       (fr_phy),
        .field5    (fr_f5),
        .payload   (fr_payload),
        .fall_tick (fall_tick),
        .rise_tick (rise_tick),
        .mdio_i    (mdio_i),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .active    (fr_active),
        .last      (fr_last),
        .rdata     (fr_rdata),
        .ta_err    (fr_ta_err)
    );

    // next state
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: if (req_valid) state_n = req_ext ? ST_ADDR : ST_DATA;
            ST_ADDR: if (fr_last)   state_n = ST_GAP;
            ST_GAP:  if (fall_tick) state_n = ST_DATA;
            ST_DATA: if (fr_last)   state_n = ST_IDLE;
            default:                state_n = ST_IDLE;
        endcase
    end

    // state register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            rd_q  <= 1'b0;
            phy_q <= '0;
            dev_q <= '0;
            wd_q  <= '0;
        end else begin
            state <= state_n;
            if (state == ST_IDLE && req_valid) begin
                rd_q  <= req_read;
                phy_q <= req_phy;
                dev_q <= req_addr[20:16];
                wd_q  <= req_wdata;
            end
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done  <= 1'b0;
            err   <= 1'b0;
            rdata <= '0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            if (state == ST_DATA && fr_last) begin
                done <= 1'b1;
                err  <= rd_q && fr_ta_err;
                if (rd_q)
                    rdata <= fr_ta_err ? 16'hFFFF : fr_rdata;
            end
        end
    end

    assert_idle_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe);

    assert_gap_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GAP) |-> (!mdio_oe && !fr_active));

    assert_err_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !$past(done)));

    assert_hold_request_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(phy_q) && $stable(wd_q) && $stable(rd_q)));

    assert_stable_at_rise_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> $stable(mdio_o));

endmodule

// File: tb/test_mdio_master.sv
module test_mdio_master;
    localparam int DIV = 2;
    localparam int MAXB = 200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_read = 1'b0, req_ext = 1'b0;
    logic [4:0]  req_phy = '0;
    logic [20:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, done, err, mdc, mdio_o, mdio_oe;
    logic [15:0] rdata;
    logic        mdio_i = 1'b1;

    always #4 clk = ~clk;

    mdio_master #(.CLK_DIV(DIV), .PRE_LEN(32)) i_mdio_master (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_read(req_read),
        .req_ext(req_ext), .req_phy(req_phy), .req_addr(req_addr),
        .req_wdata(req_wdata), .busy(busy), .done(done), .err(err),
        .rdata(rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .mdio_i(mdio_i)
    );

    int checks = 0, fails = 0;
    bit e_oe [MAXB], e_v [MAXB], e_drv [MAXB];
    bit r_oe [MAXB], r_v [MAXB];
    int n_exp = 0, n_rec = 0;
    int cyc = 0, last_rise = 0, per_bad = 0, stab_bad = 0;
    bit mdc_d = 1'b0, prev_o = 1'b0;
    bit exp_rd, exp_bad;
    logic [15:0] exp_rdata;
    string tag;

    task automatic check(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // bus monitor / PHY model
    always @(negedge clk) begin
        cyc++;
        if (mdc && !mdc_d) begin
            if (n_rec < MAXB) begin
                r_oe[n_rec] = mdio_oe;
                r_v[n_rec]  = mdio_o;
            end
            if (mdio_oe && mdio_o != prev_o) stab_bad++;
            if (n_rec > 0 && cyc - last_rise != 2 * DIV) per_bad++;
            last_rise = cyc;
            n_rec++;
            mdio_i = (n_rec < n_exp) ? e_drv[n_rec] : 1'b1;
        end
        prev_o = mdio_o;
        mdc_d  = mdc;
    end

    function automatic void push(bit oe, bit v, bit d);
        if (n_exp < MAXB) begin
            e_oe[n_exp] = oe; e_v[n_exp] = v; e_drv[n_exp] = d;
        end
        n_exp++;
    endfunction

    function automatic void build(bit [3:0] code, bit [4:0] phy, bit [4:0] f5,
                                  bit rd, bit [15:0] pay, bit ta2);
        for (int i = 0; i < 32; i++) push(1, 1, 1);
        for (int i = 3; i >= 0; i--) push(1, code[i], 1);
        for (int i = 4; i >= 0; i--) push(1, phy[i], 1);
        for (int i = 4; i >= 0; i--) push(1, f5[i], 1);
        if (rd) begin
            push(0, 0, 1);
            push(0, 0, ta2);
            for (int i = 15; i >= 0; i--) push(0, 0, pay[i]);
        end else begin
            push(1, 1, 0);
            push(1, 0, 0);
            for (int i = 15; i >= 0; i--) push(1, pay[i], 0);
        end
    endfunction

    // called at a negedge with the design idle
    task automatic issue(bit rd, bit ext, bit [4:0] phy, bit [20:0] addr,
                         bit [15:0] wd, bit [15:0] pdata, bit bad);
        n_exp = 0; n_rec = 0; mdio_i = 1'b1;
        if (ext) begin
            build(4'b0000, phy, addr[20:16], 0, addr[15:0], 0);
            push(0, 0, 1);
            build(rd ? 4'b0011 : 4'b0001, phy, addr[20:16], rd, rd ? pdata : wd, bad);
            tag = rd ? "R3 R5 R6 R8" : "R3 R5 R6 R7";
        end else begin
            build(rd ? 4'b0110 : 4'b0101, phy, addr[4:0], rd, rd ? pdata : wd, bad);
            tag = rd ? "R3 R4 R8" : "R3 R4 R7";
        end
        exp_rd = rd; exp_bad = rd && bad;
        exp_rdata = bad ? 16'hFFFF : pdata;
        req_read = rd; req_ext = ext; req_phy = phy; req_addr = addr; req_wdata = wd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // returns at the negedge where done is seen
    task automatic finish_req();
        int first_bad;
        while (!done) @(negedge clk);
        check(n_rec == n_exp, tag, "rising edge count", n_rec, n_exp);
        first_bad = -1;
        for (int k = 0; k < n_exp && k < MAXB; k++) begin
            if (first_bad < 0 && (r_oe[k] != e_oe[k] || (e_oe[k] && r_v[k] != e_v[k])))
                first_bad = k;
        end
        check(first_bad < 0, tag, "frame bits (first bad index / expected -1)",
              first_bad, -1);
        check(err == exp_bad, "R9", "err at done", err, exp_bad);
        if (exp_rd)
            check(rdata == exp_rdata, exp_bad ? "R9" : "R8", "rdata", rdata, exp_rdata);
    endtask

    task automatic idle_check();
        @(negedge clk);
        check(!busy && !mdc && !mdio_oe, "R1", "idle busy/mdc/oe",
              {busy, mdc, mdio_oe}, 0);
        check(!done, "R10", "done single pulse", done, 0);
    endtask

    bit finished = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !mdc && !mdio_oe && !done && !err, "R1", "reset state",
              {busy, mdc, mdio_oe, done, err}, 0);

        // sweep: direction x addressing x field patterns
        for (int rd = 0; rd < 2; rd++)
            for (int ext = 0; ext < 2; ext++)
                for (int p = 0; p < 4; p++) begin
                    bit [4:0]  phy;
                    bit [20:0] addr;
                    bit [15:0] wd, pd;
                    phy  = 5'(p * 10 + 1);
                    addr = {5'(p * 7 + 3), 16'hA5C3 ^ 16'(p * 16'h1111)};
                    wd   = 16'h8001 ^ 16'(p * 16'h0F3C);
                    pd   = 16'h7E81 + 16'(p * 16'h1357);
                    issue(rd[0], ext[0], phy, addr, wd, pd, 1'b0);
                    finish_req();
                    idle_check();
                end

        // boundary: all-ones and all-zeros fields
        issue(1'b0, 1'b1, 5'h1F, 21'h1FFFFF, 16'hFFFF, 16'h0, 1'b0);
        finish_req(); idle_check();
        issue(1'b1, 1'b0, 5'h00, 21'h0, 16'h0, 16'h0000, 1'b0);
        finish_req(); idle_check();

        // turnaround fault, both addressing styles
        issue(1'b1, 1'b0, 5'h04, 21'h00011, 16'h0, 16'h1234, 1'b1);
        finish_req(); idle_check();
        issue(1'b1, 1'b1, 5'h09, 21'h0ABCD5, 16'h0, 16'h4321, 1'b1);
        finish_req(); idle_check();

        // request while busy is ignored (R11)
        issue(1'b1, 1'b0, 5'h02, 21'h00005, 16'h0, 16'hC0DE, 1'b0);
        repeat (40) @(negedge clk);
        req_read = 1'b0; req_ext = 1'b1; req_phy = 5'h1C; req_addr = 21'h12345;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        tag = "R11 R8";
        finish_req(); idle_check();

        // back-to-back: new request on the done cycle (R11, R10)
        issue(1'b0, 1'b1, 5'h06, 21'h0E0F0F, 16'h3C5A, 16'h0, 1'b0);
        finish_req();
        issue(1'b1, 1'b1, 5'h11, 21'h05F00D, 16'h0, 16'hBEEF, 1'b0);
        tag = "R11 R10 R6";
        finish_req(); idle_check();

        check(per_bad == 0, "R2", "mdc period violations", per_bad, 0);
        check(stab_bad == 0, "R12", "mdio_o change before rise", stab_bad, 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=expired expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule